// File: doc/BRIEF.md
# Serial Shift Engine with Start Detection

This block is a low-level serial engine that software turns into a three-wire (SPI-style) or two-wire (I2C-style) port, as master or slave. It holds an 8-bit shift register that moves data in at its least significant end from the data-in pin and presents its most significant bit on the data output. A 4-bit edge counter tracks clock activity, and its wrap marks a finished byte. In two-wire mode a detector flags a start condition on the bus.

The shift clock has three possible sources: the external clock pin (sampling on its rising or its falling edge), a one-shot strobe written by software, or a compare pulse from a timer. Software drives a master clock by toggling an output latch that the board loops back to the clock pin. Framing, addressing and acknowledge handling belong to software. The engine only shifts, counts, flags and stretches the clock.

A small register port gives access to three 8-bit registers. Address 0 is control, address 1 is status/counter and address 2 is data. Read data is combinational on the address.

Top module: `ser_shift_top`

## Requirements
- R1: After synchronous reset, control, status and data read as 0x00. `irq_o`, `do_o`, `sck_o`, `sda_low_o` and `scl_low_o` are all 0, and the clock latch holds 1.
- R2: With clock select 2 (control bits [3:2] = 2'b10), each rising edge of `sck_i` shifts the data register left by one and puts `di_i` into bit 0, so a byte arrives MSB first.
- R3: Data out updates on the clock edge opposite to the sampling edge. With select 2 the output latch takes bit 7 on a falling edge. With select 3 (sample on falling edges) it takes bit 7 on a rising edge. A write to the data register loads the latch with bit 7 of the written value.
- R4: With select 2 or 3 the counter (status bits [3:0]) counts both edges of `sck_i`. When it wraps from 15 to 0 it sets the overflow flag (status bit 6), so 16 edges complete one byte.
- R5: With select 0, writing control with bit 4 set gives exactly one shift and one count one cycle after the write. The output latch then takes the new bit 7. Bit 4 reads back as 0.
- R6: With select 1, each cycle in which `timer_evt_i` is high gives one shift and one count. The timer input has no effect under select 2 or 3. The control strobe has no effect under any select other than 0.
- R7: With wire mode 0 (control bits [1:0] = 2'b00) the pin outputs `do_o`, `sda_low_o` and `scl_low_o` stay 0. Shifting from `di_i` and counting still work.
- R8: In two-wire mode (control bit 1 set), `di_i` falling while `sck_i` is high in both this cycle and the previous one sets the start flag (status bit 7). In three-wire mode (2'b01) the same waveform sets nothing.
- R9: In two-wire mode `scl_low_o` is 1 whenever the overflow flag is set. It stays 1 until software clears the flag.
- R10: Writing status with 1 in bit 7 or bit 6 clears that flag, and writing 0 leaves it set. Bits [3:0] of a status write load the counter.
- R11: `irq_o` is high when the start flag is set with start enable (control bit 6), or when the overflow flag is set with overflow enable (control bit 7).
- R12: Writing control with bit 5 set toggles the clock latch. In three-wire mode `sck_o` shows the latch and `do_o` shows the output latch. In two-wire mode `scl_low_o` is also 1 while the clock latch is 0, and `sda_low_o` is the inverse of the output latch.
- R13: A data-register write in the same cycle as a shift event wins over the shift. A status write in the same cycle as a count event wins over the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| di_i | input | 1 | Serial data input pin (two-wire data line in two-wire mode) |
| sck_i | input | 1 | Serial clock pin input |
| timer_evt_i | input | 1 | Timer compare pulse, used as the shift clock under select 1 |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 control, 1 status/counter, 2 data |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for `addr_i` |
| do_o | output | 1 | Three-wire data output |
| sck_o | output | 1 | Three-wire master clock output (clock latch) |
| sda_low_o | output | 1 | Two-wire data line pull-down request |
| scl_low_o | output | 1 | Two-wire clock line pull-down request (master low phase or hold) |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench aims at edge polarity. A design that updates data out on the sampling edge would show a changed `do_o` right after the rising edge, when the bench still expects the old bit. Under select 3 the same design would miss the change on the rising edge. The counter is loaded with 15 so that a single edge must set overflow and raise the two-wire clock hold. An off-by-one wrap or a flag that clears itself would release `scl_low_o` early. Two start-detect cases check the qualifiers: a fall of the data line in three-wire mode, and a fall while the clock is low. Both must leave the start flag clear. The remaining cases cover precedence and isolation. A data write lands on the same cycle as a rising clock and must win over the shift. A timer pulse and a strobe are applied under external clocking and must leave data and counter unchanged.

// File: rtl/ser_shift_pkg.sv
package ser_shift_pkg;

    localparam int REG_W = 8;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    // control write-only action bits
    localparam int CTRL_STROBE_BIT = 4;
    localparam int CTRL_TOGGLE_BIT = 5;

    typedef enum logic [1:0] {
        WM_OFF   = 2'b00,
        WM_THREE = 2'b01,
        WM_TWO   = 2'b10,
        WM_TWO_B = 2'b11
    } wire_mode_e;

    typedef enum logic [1:0] {
        CS_STROBE   = 2'b00,
        CS_TIMER    = 2'b01,
        CS_EXT_RISE = 2'b10,
        CS_EXT_FALL = 2'b11
    } clk_src_e;

    typedef struct packed {
        logic       ovf_ie;
        logic       start_ie;
        clk_src_e   cs;
        wire_mode_e mode;
    } ctrl_t;

    // one-cycle actions produced by the clock selector
    typedef struct packed {
        logic shift;     // sample di into the shift register
        logic count;     // advance the edge counter
        logic push;      // copy MSB into the output latch (opposite edge)
        logic internal;  // shift came from strobe or timer
    } clk_evt_t;

    function automatic logic is_two_wire(input wire_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/ser_clk_sel.sv
module ser_clk_sel
    import ser_shift_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sck_i,
    input  clk_src_e cs_i,
    input  logic     strobe_i,
    input  logic     timer_evt_i,
    output clk_evt_t evt_o
);

    logic sck_q;
    logic rise;
    logic fall;

    always_ff @(posedge clk) begin
        if (rst) sck_q <= 1'b0;
        else     sck_q <= sck_i;
    end

    assign rise = sck_i & ~sck_q;
    assign fall = ~sck_i & sck_q;

    always_comb begin
        evt_o = '0;
        unique case (cs_i)
            CS_STROBE: begin
                evt_o.shift    = strobe_i;
                evt_o.count    = strobe_i;
                evt_o.internal = strobe_i;
            end
            CS_TIMER: begin
                evt_o.shift    = timer_evt_i;
                evt_o.count    = timer_evt_i;
                evt_o.internal = timer_evt_i;
            end
            CS_EXT_RISE: begin
                evt_o.shift = rise;
                evt_o.push  = fall;
                evt_o.count = rise | fall;
            end
            CS_EXT_FALL: begin
                evt_o.shift = fall;
                evt_o.push  = rise;
                evt_o.count = rise | fall;
            end
            default: evt_o = '0;
        endcase
    end

    // R3: sampling and output update never share an edge
    assert_edge_split_R3: assert property (@(posedge clk) disable iff (rst)
        !(evt_o.shift && evt_o.push));

    // R6: external selects ignore timer and strobe when the pin is still
    assert_ext_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (cs_i[1] && (sck_i == sck_q)) |-> !evt_o.count);

endmodule

// File: rtl/ser_shift_reg.sv
module ser_shift_reg
    import ser_shift_pkg::*;
#(
    parameter int DW = REG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          di_i,
    input  clk_evt_t      evt_i,
    input  logic          load_en_i,
    input  logic [DW-1:0] load_data_i,
    output logic [DW-1:0] shreg_o,
    output logic          out_latch_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_o     <= '0;
            out_latch_o <= 1'b0;
        end else if (load_en_i) begin
            shreg_o     <= load_data_i;
            out_latch_o <= load_data_i[DW-1];
        end else begin
            if (evt_i.shift)
                shreg_o <= {shreg_o[DW-2:0], di_i};
            if (evt_i.shift && evt_i.internal)
                out_latch_o <= shreg_o[DW-2];
            else if (evt_i.push)
                out_latch_o <= shreg_o[DW-1];
        end
    end

    assert_shift_in_R2: assert property (@(posedge clk) disable iff (rst)
        (evt_i.shift && !load_en_i) |=>
            (shreg_o == {$past(shreg_o[DW-2:0]), $past(di_i)}));

    assert_load_wins_R13: assert property (@(posedge clk) disable iff (rst)
        load_en_i |=> (shreg_o == $past(load_data_i)));

    assert_latch_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!load_en_i && !evt_i.push && !evt_i.shift) |=> $stable(out_latch_o));

endmodule

// File: rtl/ser_edge_cnt.sv
module ser_edge_cnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          count_i,
    input  logic          wr_en_i,
    input  logic [CW-1:0] wr_val_i,
    output logic [CW-1:0] cnt_o,
    output logic          wrap_o
);

    localparam logic [CW-1:0] CNT_TOP = '1;

    always_ff @(posedge clk) begin
        if (rst)          cnt_o <= '0;
        else if (wr_en_i) cnt_o <= wr_val_i;
        else if (count_i) cnt_o <= cnt_o + 1'b1;
    end

    assign wrap_o = count_i & ~wr_en_i & (cnt_o == CNT_TOP);

    assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
        (count_i && !wr_en_i) |=> (cnt_o == $past(cnt_o) + 1'b1));

    assert_write_wins_R13: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> (cnt_o == $past(wr_val_i)));

endmodule

// File: rtl/ser_start_det.sv
module ser_start_det (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic sck_i,
    input  logic di_i,
    output logic start_o
);

    logic sck_q;
    logic di_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            di_q  <= 1'b0;
        end else begin
            sck_q <= sck_i;
            di_q  <= di_i;
        end
    end

    assign start_o = en_i & sck_i & sck_q & di_q & ~di_i;

    assert_start_needs_high_clk_R8: assert property (@(posedge clk) disable iff (rst)
        start_o |-> ($past(sck_i) && $past(di_i)));

endmodule

// File: rtl/ser_shift_top.sv
module ser_shift_top
    import ser_shift_pkg::*;
#(
    parameter int DATA_W = REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              di_i,
    input  logic              sck_i,
    input  logic              timer_evt_i,
    input  logic              wr_en_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              do_o,
    output logic              sck_o,
    output logic              sda_low_o,
    output logic              scl_low_o,
    output logic              irq_o
);

    localparam int CNT_W  = $clog2(DATA_W) + 1;
    localparam int PAD_W  = DATA_W - 2 - CNT_W;
    localparam int BIT_SF = DATA_W - 1;   // start flag
    localparam int BIT_OF = DATA_W - 2;   // overflow flag

    ctrl_t             ctrl_q;
    logic              strobe_q;
    logic              sck_latch_q;
    logic              start_f;
    logic              ovf_f;
    clk_evt_t          evt;
    logic [DATA_W-1:0] shreg;
    logic              out_latch;
    logic [CNT_W-1:0]  cnt;
    logic              wrap;
    logic              start_pulse;
    logic              wr_ctrl;
    logic              wr_stat;
    logic              wr_data;
    logic              two_wire;
    logic              three_wire;

    assign wr_ctrl    = wr_en_i && (addr_i == ADDR_CTRL);
    assign wr_stat    = wr_en_i && (addr_i == ADDR_STAT);
    assign wr_data    = wr_en_i && (addr_i == ADDR_DATA);
    assign two_wire   = is_two_wire(ctrl_q.mode);
    assign three_wire = (ctrl_q.mode == WM_THREE);

    // control register, strobe pulse and clock latch
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q      <= '0;
            strobe_q    <= 1'b0;
            sck_latch_q <= 1'b1;
        end else begin
            strobe_q <= wr_ctrl & wdata_i[CTRL_STROBE_BIT];
            if (wr_ctrl) begin
                ctrl_q.ovf_ie   <= wdata_i[7];
                ctrl_q.start_ie <= wdata_i[6];
                ctrl_q.cs       <= clk_src_e'(wdata_i[3:2]);
                ctrl_q.mode     <= wire_mode_e'(wdata_i[1:0]);
                if (wdata_i[CTRL_TOGGLE_BIT])
                    sck_latch_q <= ~sck_latch_q;
            end
        end
    end

    // flags: hardware set wins over write-one-to-clear
    always_ff @(posedge clk) begin
        if (rst) begin
            start_f <= 1'b0;
            ovf_f   <= 1'b0;
        end else begin
            if (start_pulse)                  start_f <= 1'b1;
            else if (wr_stat && wdata_i[BIT_SF]) start_f <= 1'b0;
            if (wrap)                         ovf_f <= 1'b1;
            else if (wr_stat && wdata_i[BIT_OF]) ovf_f <= 1'b0;
        end
    end

    ser_clk_sel u_clk_sel (
        .clk         (clk),
        .rst         (rst),
        .sck_i       (sck_i),
        .cs_i        (ctrl_q.cs),
        .strobe_i    (strobe_q),
        .timer_evt_i (timer_evt_i),
        .evt_o       (evt)
    );

    ser_shift_reg #(.DW(DATA_W)) u_shreg (
        .clk         (clk),
        .rst         (rst),
        .di_i        (di_i),
        .evt_i       (evt),
        .load_en_i   (wr_data),
        .load_data_i (wdata_i),
        .shreg_o     (shreg),
        .out_latch_o (out_latch)
    );

    ser_edge_cnt #(.CW(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .count_i  (evt.count),
        .wr_en_i  (wr_stat),
        .wr_val_i (wdata_i[CNT_W-1:0]),
        .cnt_o    (cnt),
        .wrap_o   (wrap)
    );

    ser_start_det u_start (
        .clk     (clk),
        .rst     (rst),
        .en_i    (two_wire),
        .sck_i   (sck_i),
        .di_i    (di_i),
        .start_o (start_pulse)
    );

    // pin-side outputs
    assign do_o      = three_wire & out_latch;
    assign sck_o     = three_wire & sck_latch_q;
    assign sda_low_o = two_wire & ~out_latch;
    assign scl_low_o = two_wire & (ovf_f | ~sck_latch_q);
    assign irq_o     = (start_f & ctrl_q.start_ie) | (ovf_f & ctrl_q.ovf_ie);

    always_comb begin
        unique case (addr_i)
            ADDR_CTRL: rdata_o = {ctrl_q.ovf_ie, ctrl_q.start_ie, 2'b00,
                                  ctrl_q.cs, ctrl_q.mode};
            ADDR_STAT: rdata_o = {start_f, ovf_f, {PAD_W{1'b0}}, cnt};
            ADDR_DATA: rdata_o = shreg;
            default:   rdata_o = '0;
        endcase
    end

    assert_start_only_two_wire_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(start_f) |-> $past(two_wire));

    assert_ovf_from_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_f) |-> ($past(cnt) == {CNT_W{1'b1}}));

    assert_hold_until_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (ovf_f && !(wr_stat && wdata_i[BIT_OF])) |=> ovf_f);

    assert_hold_pin_R9: assert property (@(posedge clk) disable iff (rst)
        (two_wire && ovf_f) |-> scl_low_o);

    assert_w1c_start_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && wdata_i[BIT_SF] && !start_pulse) |=> !start_f);

    assert_irq_source_R11: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (start_f || ovf_f));

    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
        strobe_q |=> !strobe_q || $past(wr_ctrl));

endmodule

// File: tb/ser_shift_top_tb_top.sv
module ser_shift_top_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       di, sck, tmr, wr_en;
    logic [1:0] addr;
    logic [7:0] wdata, rdata;
    logic       do_o, sck_o, sda_low, scl_low, irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    ser_shift_top dut_i (
        .clk(clk), .rst(rst), .di_i(di), .sck_i(sck), .timer_evt_i(tmr),
        .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .do_o(do_o), .sck_o(sck_o), .sda_low_o(sda_low), .scl_low_o(scl_low),
        .irq_o(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        addr = a;
        #0.5;
        v = rdata;
    endtask

    task automatic set_sck(input logic v);
        @(negedge clk);
        sck = v;
        @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd0, v); check("R1 ctrl", v, 8'h00);
        rd(2'd1, v); check("R1 status", v, 8'h00);
        rd(2'd2, v); check("R1 data", v, 8'h00);
        check("R1 pins", {4'h0, irq, do_o, sck_o, scl_low | sda_low}, 8'h00);
    endtask

    task automatic t_ext_rise_byte();
        logic [7:0] v;
        logic [7:0] pat = 8'hA5;
        wr(2'd0, 8'h09); wr(2'd1, 8'hC0); wr(2'd2, 8'h00);
        for (int i = 7; i >= 0; i--) begin
            di = pat[i];
            set_sck(1'b1);
            set_sck(1'b0);
            if (i == 6) begin
                rd(2'd1, v); check("R4 count after 4 edges", v, 8'h04);
            end
        end
        rd(2'd2, v); check("R2 byte shifted MSB first", v, 8'hA5);
        rd(2'd1, v); check("R4 wrap sets overflow, count 0", v, 8'h40);
    endtask

    task automatic t_opposite_edge();
        logic [7:0] v;
        wr(2'd0, 8'h09); wr(2'd2, 8'h80);
        check("R3 data write loads output", {7'd0, do_o}, 8'h01);
        di = 1'b0;
        set_sck(1'b1);
        check("R3 rise does not move output (sel 2)", {7'd0, do_o}, 8'h01);
        set_sck(1'b0);
        check("R3 fall updates output (sel 2)", {7'd0, do_o}, 8'h00);
        wr(2'd0, 8'h0D); wr(2'd2, 8'h40);
        set_sck(1'b1);
        di = 1'b1;
        set_sck(1'b0);
        rd(2'd2, v); check("R3 sel 3 samples on fall", v, 8'h81);
        check("R3 fall does not move output (sel 3)", {7'd0, do_o}, 8'h00);
        set_sck(1'b1);
        check("R3 rise updates output (sel 3)", {7'd0, do_o}, 8'h01);
        set_sck(1'b0);
    endtask

    task automatic t_strobe();
        logic [7:0] v;
        wr(2'd0, 8'h01); wr(2'd1, 8'hC0); wr(2'd2, 8'h40);
        di = 1'b0;
        wr(2'd0, 8'h11);
        tick();
        rd(2'd2, v); check("R5 strobe shifts once", v, 8'h80);
        rd(2'd1, v); check("R5 strobe counts once", v, 8'h01);
        check("R5 output takes new MSB", {7'd0, do_o}, 8'h01);
        rd(2'd0, v); check("R5 strobe bit reads 0", v, 8'h01);
        tick(); tick();
        rd(2'd1, v); check("R5 no second count", v, 8'h01);
    endtask

    task automatic t_timer();
        logic [7:0] v;
        wr(2'd0, 8'h05); wr(2'd1, 8'hC0); wr(2'd2, 8'h00);
        di = 1'b1;
        @(negedge clk); tmr = 1'b1;
        @(negedge clk); tmr = 1'b0;
        rd(2'd2, v); check("R6 timer shifts", v, 8'h01);
        rd(2'd1, v); check("R6 timer counts", v, 8'h01);
        wr(2'd0, 8'h09);
        @(negedge clk); tmr = 1'b1;
        @(negedge clk); tmr = 1'b0;
        wr(2'd0, 8'h19);
        tick(); tick();
        rd(2'd2, v); check("R6 timer/strobe ignored under ext: data", v, 8'h01);
        rd(2'd1, v); check("R6 timer/strobe ignored under ext: count", v, 8'h01);
    endtask

    task automatic t_no_mode();
        logic [7:0] v;
        wr(2'd0, 8'h08); wr(2'd1, 8'hC0); wr(2'd2, 8'hFF);
        check("R7 outputs quiet with mode 0", {5'd0, do_o, sda_low, scl_low}, 8'h00);
        di = 1'b0;
        set_sck(1'b1); set_sck(1'b0);
        set_sck(1'b1); set_sck(1'b0);
        rd(2'd2, v); check("R7 shifts with mode 0", v, 8'hFC);
        rd(2'd1, v); check("R7 counts with mode 0", v, 8'h04);
    endtask

    task automatic t_start();
        logic [7:0] v;
        wr(2'd0, 8'h0A); wr(2'd1, 8'hC0);
        di = 1'b1; tick();
        di = 1'b0; tick(); tick();
        rd(2'd1, v); check("R8 fall with clock low: no start", v & 8'h80, 8'h00);
        di = 1'b1; tick();
        set_sck(1'b1);
        di = 1'b0; tick(); tick();
        rd(2'd1, v); check("R8 start detected", v & 8'h80, 8'h80);
        wr(2'd1, 8'h80);
        rd(2'd1, v); check("R10 start cleared by write one", v & 8'h80, 8'h00);
        wr(2'd0, 8'h09);
        di = 1'b1; tick();
        di = 1'b0; tick(); tick();
        rd(2'd1, v); check("R8 no start in three-wire", v & 8'h80, 8'h00);
        set_sck(1'b0);
    endtask

    task automatic t_hold();
        logic [7:0] v;
        wr(2'd0, 8'h0A); wr(2'd1, 8'hCF);
        check("R9 no hold before wrap", {7'd0, scl_low}, 8'h00);
        set_sck(1'b1);
        rd(2'd1, v); check("R4 single edge from 15 wraps", v, 8'h40);
        check("R9 clock held low on overflow", {7'd0, scl_low}, 8'h01);
        wr(2'd1, 8'h00);
        rd(2'd1, v); check("R10 write zero keeps flag", v, 8'h40);
        check("R9 hold persists", {7'd0, scl_low}, 8'h01);
        wr(2'd1, 8'h40);
        rd(2'd1, v); check("R10 overflow cleared", v, 8'h00);
        check("R9 hold released", {7'd0, scl_low}, 8'h00);
        set_sck(1'b0);
    endtask

    task automatic t_irq();
        wr(2'd0, 8'h8A); wr(2'd1, 8'hCF);
        check("R11 irq idle", {7'd0, irq}, 8'h00);
        set_sck(1'b1);
        check("R11 irq on enabled overflow", {7'd0, irq}, 8'h01);
        wr(2'd0, 8'h4A);
        check("R11 irq masked", {7'd0, irq}, 8'h00);
        wr(2'd1, 8'hC0);
        set_sck(1'b0);
    endtask

    task automatic t_pins();
        logic [7:0] v;
        wr(2'd0, 8'h01);
        check("R12 sck_o idle high", {7'd0, sck_o}, 8'h01);
        wr(2'd0, 8'h21);
        check("R12 toggle drives sck_o low", {7'd0, sck_o}, 8'h00);
        rd(2'd0, v); check("R12 toggle bit reads 0", v, 8'h01);
        wr(2'd0, 8'h21);
        wr(2'd0, 8'h02); wr(2'd2, 8'h00);
        check("R12 two-wire data pulled low", {6'd0, sda_low, scl_low}, 8'h02);
        wr(2'd2, 8'h80);
        check("R12 two-wire data released", {7'd0, sda_low}, 8'h00);
        wr(2'd0, 8'h22);
        check("R12 two-wire clock low phase", {7'd0, scl_low}, 8'h01);
        wr(2'd0, 8'h22);
    endtask

    task automatic t_precedence();
        logic [7:0] v;
        wr(2'd0, 8'h09); wr(2'd1, 8'hC0); wr(2'd2, 8'h00);
        di = 1'b1;
        @(negedge clk);
        wr_en = 1'b1; addr = 2'd2; wdata = 8'h3C; sck = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        rd(2'd2, v); check("R13 data write beats shift", v, 8'h3C);
        rd(2'd1, v); check("R13 count still advanced", v, 8'h01);
        @(negedge clk);
        wr_en = 1'b1; addr = 2'd1; wdata = 8'h05; sck = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        rd(2'd1, v); check("R13 status write beats count", v, 8'h05);
    endtask

    initial begin
        rst = 1'b1; di = 1'b0; sck = 1'b0; tmr = 1'b0;
        wr_en = 1'b0; addr = 2'd0; wdata = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ext_rise_byte();
        t_opposite_edge();
        t_strobe();
        t_timer();
        t_no_mode();
        t_start();
        t_hold();
        t_irq();
        t_pins();
        t_precedence();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all R) actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule